// File: doc/BRIEF.md
# Legacy Interrupt Pin Router

This block connects the four legacy level-sensitive PCI interrupt lines (INTA to INTD, numbered 0 to 3) to system interrupt numbers that software picks. Each line has a signed target register. A non-negative value routes the line to that interrupt number. A negative value leaves the line unrouted.

Software programs the table through a one-cycle strobe that carries a line index and a target value. An index that names no line is refused: the table is left alone, and an error flag pulses on the next cycle. An interrupt controller further down the chain asks for a line's route by placing the index on a query port. It reads back the target number and an enable flag in the same cycle. Each incoming line level also passes straight to its own outgoing interrupt line.

Top module: `intx_router`

## Requirements
- R1: The router has exactly four lines, numbered 0 to 3. The index ports are 3 bits wide, so indices 4 to 7 can be presented.
- R2: A write with `cfg_valid` high and `cfg_index` from 0 to 3 loads `cfg_data` (16-bit two's complement) into that line's target register at the clock edge. From the next cycle a query of that line returns it on `qry_target`.
- R3: After synchronous reset every target register holds -1 (16'hFFFF), so every in-range query reports disabled.
- R4: A write with `cfg_index` of 4 or more changes no target register. It raises `cfg_err` for exactly the one cycle after the write edge.
- R5: A valid in-range write, and any cycle without `cfg_valid`, leaves `cfg_err` low in the following cycle.
- R6: For a query index of 0 to 3, `qry_enabled` is 1 exactly when the stored target is non-negative (sign bit 0). `qry_target` always carries the stored value.
- R7: A query index of 4 or more reports `qry_enabled` = 0 and `qry_target` = 16'hFFFF.
- R8: Each `irq_out[i]` equals `pin_level[i]` in the same cycle, for all four lines, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Write strobe for the route table |
| cfg_index | input | 3 | Line index of the write |
| cfg_data | input | 16 | Signed target number to store |
| cfg_err | output | 1 | Registered one-cycle flag for a refused write |
| qry_index | input | 3 | Line index being queried |
| qry_enabled | output | 1 | Route is enabled for the queried line |
| qry_target | output | 16 | Stored target number of the queried line |
| pin_level | input | 4 | Incoming interrupt line levels |
| irq_out | output | 4 | Forwarded interrupt line levels |

## Verification
The write path is driven with every index from 0 to 7. The target values used are 0, 1, 5, 32767, -1, -2 and -32768. This sets the sign boundary that decides the enable flag apart from the value stored, and sets accepted indices apart from refused ones. After each write, all eight query indices are read back against a model of the table in the bench, which shows that a write touches only its own line. A refused write is checked both through the error pulse and through an unchanged table. The forwarding path is swept over all sixteen level patterns, so a swapped or stuck line shows up.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned LINES_DEF = 4;
  localparam int unsigned IDX_W_DEF = 3;
  localparam int unsigned TGT_W_DEF = 16;

  typedef enum logic {
    ROUTE_OFF = 1'b0,
    ROUTE_ON  = 1'b1
  } route_mode_e;
endpackage

// File: rtl/intx_route_regs.sv
module intx_route_regs #(
  parameter int unsigned LINES = 4,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TGT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [TGT_W-1:0]       wr_val,
  output logic                   wr_bad,
  output logic [LINES*TGT_W-1:0] table_flat
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic idx_ok;
  assign idx_ok = (wr_idx <= LAST_IDX);

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    logic [TGT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '1;
      end else if (wr_en && idx_ok && (wr_idx == IDX_W'(g))) begin
        slot_q <= wr_val;
      end
    end
    assign table_flat[g*TGT_W +: TGT_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bad <= 1'b0;
    end else begin
      wr_bad <= wr_en && !idx_ok;
    end
  end
endmodule

// File: rtl/intx_route_decode.sv
module intx_route_decode
  import intx_pkg::*;
#(
  parameter int unsigned LINES = 4,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TGT_W = 16
) (
  input  logic [LINES*TGT_W-1:0] table_flat,
  input  logic [IDX_W-1:0]       sel_idx,
  output route_mode_e            sel_mode,
  output logic [TGT_W-1:0]       sel_target
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic [TGT_W-1:0] picked;

  always_comb begin
    picked = '1;
    for (int k = 0; k < LINES; k++) begin
      if (sel_idx == IDX_W'(k)) picked = table_flat[k*TGT_W +: TGT_W];
    end
  end

  always_comb begin
    sel_target = picked;
    if (sel_idx > LAST_IDX || picked[TGT_W-1]) sel_mode = ROUTE_OFF;
    else                                       sel_mode = ROUTE_ON;
  end
endmodule

// File: rtl/intx_level_fwd.sv
module intx_level_fwd #(
  parameter int unsigned LINES = 4
) (
  input  logic [LINES-1:0] lvl_in,
  output logic [LINES-1:0] lvl_out
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign lvl_out[g] = lvl_in[g];
  end
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_pkg::*;
#(
  parameter int unsigned LINES = LINES_DEF,
  parameter int unsigned IDX_W = IDX_W_DEF,
  parameter int unsigned TGT_W = TGT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic [TGT_W-1:0] cfg_data,
  output logic             cfg_err,
  input  logic [IDX_W-1:0] qry_index,
  output logic             qry_enabled,
  output logic [TGT_W-1:0] qry_target,
  input  logic [LINES-1:0] pin_level,
  output logic [LINES-1:0] irq_out
);
  logic [LINES*TGT_W-1:0] route_table;
  route_mode_e            mode;

  intx_route_regs #(.LINES(LINES), .IDX_W(IDX_W), .TGT_W(TGT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_valid),
    .wr_idx     (cfg_index),
    .wr_val     (cfg_data),
    .wr_bad     (cfg_err),
    .table_flat (route_table)
  );

  intx_route_decode #(.LINES(LINES), .IDX_W(IDX_W), .TGT_W(TGT_W)) u_dec (
    .table_flat (route_table),
    .sel_idx    (qry_index),
    .sel_mode   (mode),
    .sel_target (qry_target)
  );

  assign qry_enabled = (mode == ROUTE_ON);

  intx_level_fwd #(.LINES(LINES)) u_fwd (
    .lvl_in  (pin_level),
    .lvl_out (irq_out)
  );
endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk #(
  parameter int unsigned LINES = 4,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TGT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_valid,
  input logic [IDX_W-1:0] cfg_index,
  input logic [TGT_W-1:0] cfg_data,
  input logic             cfg_err,
  input logic [IDX_W-1:0] qry_index,
  input logic             qry_enabled,
  input logic [TGT_W-1:0] qry_target
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  // R4: an error pulse follows only a refused write
  a_r4_err_cause: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_valid && (cfg_index > LAST_IDX)));

  // R5: accepted writes raise no error
  a_r5_no_err_good: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_index <= LAST_IDX)) |=> !cfg_err);

  // R2: written value is visible on the next cycle
  a_r2_write_seen: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_index <= LAST_IDX)) ##1 (qry_index == $past(cfg_index))
      |-> (qry_target == $past(cfg_data)));

  // R4: a refused write leaves a held query unchanged
  a_r4_table_kept: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && (cfg_index > LAST_IDX)) ##1 $stable(qry_index)
      |-> $stable(qry_target));

  // R7: out-of-range query reads disabled
  a_r7_outrange_query: assert property (@(posedge clk) disable iff (rst)
    (qry_index > LAST_IDX) |-> (!qry_enabled && (qry_target == '1)));
endmodule

bind intx_router intx_router_chk #(.LINES(LINES), .IDX_W(IDX_W), .TGT_W(TGT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_valid   (cfg_valid),
  .cfg_index   (cfg_index),
  .cfg_data    (cfg_data),
  .cfg_err     (cfg_err),
  .qry_index   (qry_index),
  .qry_enabled (qry_enabled),
  .qry_target  (qry_target)
);

// File: tb/test_intx_router.sv
module test_intx_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0;
  logic [2:0]  cfg_index = '0;
  logic [15:0] cfg_data = '0;
  logic        cfg_err;
  logic [2:0]  qry_index = '0;
  logic        qry_enabled;
  logic [15:0] qry_target;
  logic [3:0]  pin_level = '0;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;
  int model [4];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  intx_router i_intx_router (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_index(cfg_index),
    .cfg_data(cfg_data), .cfg_err(cfg_err), .qry_index(qry_index),
    .qry_enabled(qry_enabled), .qry_target(qry_target),
    .pin_level(pin_level), .irq_out(irq_out)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 R6 R7: compare every query index against the model
  task automatic sweep_queries(input string req);
    for (int q = 0; q < 8; q++) begin
      qry_index = 3'(q);
      #1;
      if (q < 4) begin
        check({req, " R6 target"}, int'($signed(qry_target)), model[q]);
        check({req, " R6 enable"}, int'(qry_enabled), (model[q] >= 0) ? 1 : 0);
      end else begin
        check({req, " R7 target"}, int'(qry_target), 16'hFFFF);
        check({req, " R7 enable"}, int'(qry_enabled), 0);
      end
    end
  endtask

  task automatic do_write(input int idx, input int val);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_index = 3'(idx);
    cfg_data  = 16'(val);
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    if (idx < 4) begin
      model[idx] = val;
      check("R5 no error", int'(cfg_err), 0);
    end else begin
      check("R4 error pulse", int'(cfg_err), 1);
    end
    sweep_queries(idx < 4 ? "R2 write" : "R4 refused");
    @(negedge clk);
    #1;
    check("R4 R5 error clears", int'(cfg_err), 0);
  endtask

  initial begin
    int vals [7] = '{0, 1, 5, 32767, -1, -2, -32768};
    for (int i = 0; i < 4; i++) model[i] = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R3 reset error", int'(cfg_err), 0);
    sweep_queries("R3 reset");
    for (int v = 0; v < 7; v++) begin
      for (int i = 0; i < 8; i++) begin
        do_write(i, vals[(v + i) % 7]);
      end
    end
    // R8: forwarding of every level pattern, plus R1 line count
    for (int p = 0; p < 16; p++) begin
      pin_level = 4'(p);
      #1;
      check("R8 forward", int'(irq_out), p);
    end
    check("R1 line count", $bits(irq_out), 4);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule